// File: doc/BRIEF.md
# Modem Control and Status Unit

This block is the modem-handshake slice of a UART-style peripheral. It holds the control register that drives the four active-low handshake outputs: terminal ready, request to send, and two general outputs. It presents a status register that reports the four active-low handshake inputs: clear to send, set ready, ring and carrier. The inputs pass through a two-flop synchroniser. A change on an input is recorded in a sticky delta bit. A pending delta raises a modem-status interrupt request when the interrupt enable is high. A read strobe on the status register clears the delta bits.

A diagnostic loopback mode exists for self-test. In this mode the handshake outputs rest at their inactive high level and the external inputs are ignored. The four status levels are then taken from the control bits instead. The delta and interrupt logic keep running on those internal levels. A loopback flag and an automatic flow-control flag go out to the neighbouring transmitter and receiver. Baud generation, FIFOs and serial framing belong to other blocks.

Top module: `modem_ctl_unit`

## Requirements
- R1: A write strobe loads the control register on the next clock edge. Bits 7 and 6 always read back as 0. The register resets to 0. Bit layout: 0 terminal ready, 1 request to send, 2 general output 1, 3 general output 2, 4 loopback, 5 flow control.
- R2: Outside loopback, each of control bits 0 to 3 drives its matching active-low pin low when the bit is 1 and high when the bit is 0.
- R3: Outside loopback, status bits 4 (clear to send), 5 (set ready), 6 (ring) and 7 (carrier) are the complement of the matching input pin. Each bit reflects its pin two clock edges after the pin changes.
- R4: In loopback, all four output pins are held high and the external input pins have no effect on the status register.
- R5: Delta bits 0 (clear to send), 1 (set ready) and 3 (carrier) set on either direction of change of their status level. A change on a pin shows in its delta bit three clock edges after the pin changes.
- R6: Delta bit 2 (ring) sets only when the ring pin goes from low to high, which is status bit 6 falling. It does not set when status bit 6 rises.
- R7: A status read strobe clears all delta bits at that clock edge. A change detected at the same edge sets its delta bit regardless of the read.
- R8: The interrupt request is high exactly when the interrupt enable is high and at least one delta bit is set.
- R9: In loopback, status bit 7 follows control bit 3, bit 6 follows bit 2, bit 5 follows bit 0 and bit 4 follows bit 1. Delta bits and the interrupt react to these internal levels one clock edge after the control write.
- R10: The loopback flag output equals control bit 4 and the flow-control flag output equals control bit 5.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctl_wr | input | 1 | Control register write strobe |
| ctl_wdata | input | 8 | Control register write data |
| ctl_rdata | output | 8 | Control register read data |
| sts_rd | input | 1 | Status register read strobe, clears deltas |
| sts_rdata | output | 8 | Status register: levels in 7:4, deltas in 3:0 |
| msi_en | input | 1 | Modem-status interrupt enable |
| msi_req | output | 1 | Modem-status interrupt request |
| loop_en | output | 1 | Loopback flag to transmitter and receiver |
| afc_en | output | 1 | Automatic flow-control enable flag |
| dtr_n | output | 1 | Terminal ready output, active low |
| rts_n | output | 1 | Request to send output, active low |
| out1_n | output | 1 | General output 1, active low |
| out2_n | output | 1 | General output 2, active low |
| cts_n | input | 1 | Clear to send input, active low |
| dsr_n | input | 1 | Set ready input, active low |
| ri_n | input | 1 | Ring input, active low |
| dcd_n | input | 1 | Carrier input, active low |

## Verification
A status level is due two clock edges after its pin moves and the matching delta bit one edge later. The bench therefore drives pins just after a falling edge, waits three rising edges and samples at the following falling edge. A control write and the pins and flags it drives become visible one edge after the strobe. In loopback the delta bits appear one further edge later. The read-collision case asserts the read strobe for exactly the edge at which the new delta lands, then checks that the other pending delta cleared and the new one survived.

// File: rtl/mcsu_pkg.sv
package mcsu_pkg;

    localparam int NLINES      = 4;
    localparam int SYNC_STAGES = 2;

    // Line order inside every 4-bit level/delta vector
    localparam int L_CTS = 0;
    localparam int L_DSR = 1;
    localparam int L_RI  = 2;
    localparam int L_DCD = 3;

    // Control register layout (field positions decoded by software)
    typedef struct packed {
        logic [1:0] rsvd;
        logic       afc;
        logic       loop;
        logic       out2;
        logic       out1;
        logic       rts;
        logic       dtr;
    } ctl_t;

    localparam int CTL_W = $bits(ctl_t);

endpackage

// File: rtl/mcsu_sync.sv
module mcsu_sync #(
    parameter int              WIDTH   = 4,
    parameter int              STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);

    logic [WIDTH-1:0] stage_d [STAGES];
    logic [WIDTH-1:0] stage_q [STAGES];

    always_comb begin
        stage_d[0] = din;
        for (int i = 1; i < STAGES; i++) begin
            stage_d[i] = stage_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stage_q[i] <= RST_VAL;
        end else begin
            for (int i = 0; i < STAGES; i++) stage_q[i] <= stage_d[i];
        end
    end

    assign dout = stage_q[STAGES-1];

endmodule

// File: rtl/mcsu_delta.sv
module mcsu_delta #(
    parameter int               NLINES    = 4,
    parameter logic [NLINES-1:0] FALL_ONLY = 4'b0100
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NLINES-1:0] lvl,
    input  logic              clr,
    output logic [NLINES-1:0] delta
);

    typedef struct packed {
        logic [NLINES-1:0] prev;
        logic [NLINES-1:0] delta;
    } dstate_t;

    dstate_t st_d, st_q;
    logic [NLINES-1:0] chg;

    // Per-line edge detector; the parameter picks the edge rule.
    for (genvar i = 0; i < NLINES; i++) begin : g_line
        if (FALL_ONLY[i]) begin : g_fall
            assign chg[i] = st_q.prev[i] & ~lvl[i];

            // R6: a rising level never sets this delta
            p_one_edge_r6: assert property (@(posedge clk) disable iff (!rst_n)
                (lvl[i] && !st_q.prev[i] && !st_q.delta[i]) |=> !st_q.delta[i]);
        end else begin : g_any
            assign chg[i] = st_q.prev[i] ^ lvl[i];

            // R5: any change of level sets the delta, even under a read
            p_change_sets_r5: assert property (@(posedge clk) disable iff (!rst_n)
                (lvl[i] != st_q.prev[i]) |=> st_q.delta[i]);
        end
    end

    always_comb begin
        st_d       = st_q;
        st_d.prev  = lvl;
        st_d.delta = (st_q.delta & ~{NLINES{clr}}) | chg;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign delta = st_q.delta;

    // R7: deltas hold until a read
    p_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !clr |=> ((st_q.delta & $past(st_q.delta)) == $past(st_q.delta)));

    // R7: a read with no new change empties the deltas
    p_read_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && (lvl == st_q.prev)) |=> (st_q.delta == '0));

endmodule

// File: rtl/modem_ctl_unit.sv
module modem_ctl_unit
    import mcsu_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ctl_wr,
    input  logic [7:0] ctl_wdata,
    output logic [7:0] ctl_rdata,
    input  logic       sts_rd,
    output logic [7:0] sts_rdata,
    input  logic       msi_en,
    output logic       msi_req,
    output logic       loop_en,
    output logic       afc_en,
    output logic       dtr_n,
    output logic       rts_n,
    output logic       out1_n,
    output logic       out2_n,
    input  logic       cts_n,
    input  logic       dsr_n,
    input  logic       ri_n,
    input  logic       dcd_n
);

    localparam logic [NLINES-1:0] RI_FALL_MASK = NLINES'(1) << L_RI;

    ctl_t ctl_d, ctl_q;

    logic [NLINES-1:0] pin_raw;
    logic [NLINES-1:0] pin_sync;
    logic [NLINES-1:0] ext_lvl;
    logic [NLINES-1:0] loop_lvl;
    logic [NLINES-1:0] lvl;
    logic [NLINES-1:0] delta;

    // ---------------- control register ----------------
    always_comb begin
        ctl_d = ctl_q;
        if (ctl_wr) begin
            ctl_d      = ctl_t'(ctl_wdata);
            ctl_d.rsvd = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    assign ctl_rdata = ctl_q;
    assign loop_en   = ctl_q.loop;
    assign afc_en    = ctl_q.afc;

    // Outputs are active low and rest high during loopback
    assign dtr_n  = ~(ctl_q.dtr  & ~ctl_q.loop);
    assign rts_n  = ~(ctl_q.rts  & ~ctl_q.loop);
    assign out1_n = ~(ctl_q.out1 & ~ctl_q.loop);
    assign out2_n = ~(ctl_q.out2 & ~ctl_q.loop);

    // ---------------- input path ----------------
    always_comb begin
        pin_raw        = '1;
        pin_raw[L_CTS] = cts_n;
        pin_raw[L_DSR] = dsr_n;
        pin_raw[L_RI]  = ri_n;
        pin_raw[L_DCD] = dcd_n;
    end

    mcsu_sync #(
        .WIDTH  (NLINES),
        .STAGES (SYNC_STAGES),
        .RST_VAL({NLINES{1'b1}})
    ) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (pin_raw),
        .dout (pin_sync)
    );

    assign ext_lvl = ~pin_sync;

    always_comb begin
        loop_lvl        = '0;
        loop_lvl[L_CTS] = ctl_q.rts;
        loop_lvl[L_DSR] = ctl_q.dtr;
        loop_lvl[L_RI]  = ctl_q.out1;
        loop_lvl[L_DCD] = ctl_q.out2;
        lvl             = ctl_q.loop ? loop_lvl : ext_lvl;
    end

    mcsu_delta #(
        .NLINES   (NLINES),
        .FALL_ONLY(RI_FALL_MASK)
    ) u_delta (
        .clk  (clk),
        .rst_n(rst_n),
        .lvl  (lvl),
        .clr  (sts_rd),
        .delta(delta)
    );

    assign sts_rdata = {lvl, delta};
    assign msi_req   = msi_en & (|delta);

    // ---------------- assertions ----------------
    // R1: reserved bits never hold a 1
    p_rsvd_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_rdata[7:6] == 2'b00);

    // R1: written field bits appear one edge after the strobe
    p_ctl_write_r1: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_wr |=> (ctl_rdata[5:0] == $past(ctl_wdata[5:0])));

    // R4: pins idle during loopback
    p_loop_pins_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
        loop_en |-> ({dtr_n, rts_n, out1_n, out2_n} == 4'hF));

    // R8: no request while disabled
    p_irq_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !msi_en |-> !msi_req);

endmodule

// File: tb/modem_ctl_unit_tb.sv
module modem_ctl_unit_tb;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       ctl_wr;
    logic [7:0] ctl_wdata;
    logic [7:0] ctl_rdata;
    logic       sts_rd;
    logic [7:0] sts_rdata;
    logic       msi_en;
    logic       msi_req;
    logic       loop_en;
    logic       afc_en;
    logic       dtr_n, rts_n, out1_n, out2_n;
    logic       cts_n, dsr_n, ri_n, dcd_n;

    int n_chk = 0;
    int n_err = 0;

    always #2 clk = ~clk;

    modem_ctl_unit u_dut (
        .clk(clk), .rst_n(rst_n),
        .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata), .ctl_rdata(ctl_rdata),
        .sts_rd(sts_rd), .sts_rdata(sts_rdata),
        .msi_en(msi_en), .msi_req(msi_req),
        .loop_en(loop_en), .afc_en(afc_en),
        .dtr_n(dtr_n), .rts_n(rts_n), .out1_n(out1_n), .out2_n(out2_n),
        .cts_n(cts_n), .dsr_n(dsr_n), .ri_n(ri_n), .dcd_n(dcd_n)
    );

    // {pins dcd,ri,dsr,cts (active low), expected status}
    localparam logic [11:0] VEC [7] = '{
        {4'b1110, 8'h11},
        {4'b1100, 8'h32},
        {4'b1000, 8'h70},
        {4'b1100, 8'h34},
        {4'b0100, 8'hB8},
        {4'b1111, 8'h0B},
        {4'b1111, 8'h00}
    };

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic set_pins(input logic [3:0] p);
        {dcd_n, ri_n, dsr_n, cts_n} = p;
    endtask

    task automatic do_write(input logic [7:0] d);
        ctl_wr = 1'b1; ctl_wdata = d;
        @(posedge clk); @(negedge clk);
        ctl_wr = 1'b0;
    endtask

    task automatic do_read();
        sts_rd = 1'b1;
        @(posedge clk); @(negedge clk);
        sts_rd = 1'b0;
    endtask

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    function automatic logic [7:0] pins_out();
        return {4'h0, out2_n, out1_n, rts_n, dtr_n};
    endfunction

    initial begin
        repeat (20000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        rst_n = 1'b0; ctl_wr = 1'b0; ctl_wdata = '0; sts_rd = 1'b0; msi_en = 1'b0;
        set_pins(4'b1111);
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // Reset state
        chk("R1 reset ctl", ctl_rdata, 8'h00);
        chk("R3 reset status", sts_rdata, 8'h00);
        chk("R2 reset pins", pins_out(), 8'h0F);
        chk("R8 reset irq", {7'd0, msi_req}, 8'h00);

        // R1/R2/R10 register and pins
        do_write(8'hEF);
        chk("R1 reserved bits masked", ctl_rdata, 8'h2F);
        chk("R2 all pins asserted", pins_out(), 8'h00);
        chk("R10 flags", {6'd0, afc_en, loop_en}, 8'h02);
        do_write(8'h02);
        chk("R2 rts only", pins_out(), 8'h0D);
        do_write(8'h00);
        chk("R2 pins idle", pins_out(), 8'h0F);

        // Table walk: R3 R5 R6 R7 R8
        msi_en = 1'b1;
        for (int i = 0; i < 7; i++) begin
            set_pins(VEC[i][11:8]);
            step(3);
            chk($sformatf("R3/R5/R6 vector %0d", i), sts_rdata, VEC[i][7:0]);
            chk($sformatf("R8 vector %0d", i), {7'd0, msi_req}, {7'd0, |VEC[i][3:0]});
            do_read();
            chk($sformatf("R7 clear vector %0d", i), sts_rdata, {VEC[i][7:4], 4'h0});
        end

        // R8 gating
        msi_en = 1'b0;
        set_pins(4'b1110);
        step(3);
        chk("R5 cts delta", sts_rdata, 8'h11);
        chk("R8 irq gated off", {7'd0, msi_req}, 8'h00);
        msi_en = 1'b1;
        #1;
        chk("R8 irq enabled", {7'd0, msi_req}, 8'h01);
        @(negedge clk);

        // R7 read colliding with a new change
        set_pins(4'b1100);
        @(posedge clk); @(posedge clk); @(negedge clk);
        sts_rd = 1'b1;
        @(posedge clk); @(negedge clk);
        sts_rd = 1'b0;
        chk("R7 collision keeps new delta", sts_rdata, 8'h32);
        do_read();
        chk("R7 clear after collision", sts_rdata, 8'h30);
        set_pins(4'b1111);
        step(3);
        do_read();
        chk("R3 back to idle", sts_rdata, 8'h00);

        // Loopback R4 R9 R10
        do_write(8'h11);
        step(1);
        chk("R9 loop dtr to dsr", sts_rdata, 8'h22);
        chk("R4 loop pins idle", pins_out(), 8'h0F);
        chk("R10 loop flag", {7'd0, loop_en}, 8'h01);
        chk("R9 loop irq", {7'd0, msi_req}, 8'h01);
        set_pins(4'b0000);
        step(4);
        chk("R4 external pins ignored", sts_rdata, 8'h22);
        do_read();
        chk("R7 loop clear", sts_rdata, 8'h20);
        do_write(8'h1C);
        step(1);
        chk("R9/R6 loop out1 out2", sts_rdata, 8'hCA);
        do_read();
        chk("R9 loop cleared", sts_rdata, 8'hC0);
        do_write(8'h18);
        step(1);
        chk("R6 loop ring trailing edge", sts_rdata, 8'h84);
        do_read();
        do_write(8'h00);
        step(1);
        chk("R4 exit loop sees pins", sts_rdata, 8'hF3);
        chk("R2 pins after loop", pins_out(), 8'h0F);

        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

endmodule